// File: doc/BRIEF.md
# String port-input transfer unit

This unit carries out one string input step for a processor datapath. On a start pulse it takes a decoded opcode, the operand-size and address-size attributes, a 64-bit-mode flag, a direction flag, the 16-bit port register, the destination index register and the extra-segment base. It then reads one element from the port space and writes it to memory at the address that the segment base and the index form. When the write is done it reports the stepped index value.

The element is a byte, a word or a doubleword. The index advances by that element size, either up or down as the direction flag selects. The step wraps within the address width chosen for the operation. Which address widths are allowed depends on the mode. A combination that is not allowed ends the operation with a fault pulse and no bus traffic. Both the port side and the memory side use a plain request/acknowledge handshake.

Top module: `strio_unit`

## Requirements
- R1: One cycle after a legal start, `io_req` rises with `io_addr` equal to `port_reg`. `io_size` encodes the element as 0 = byte, 1 = word, 2 = doubleword.
- R2: Opcode 0x6C always moves a byte. Opcode 0x6D moves a doubleword when `opsize32` is 1 and a word when it is 0. Any other opcode is illegal.
- R3: The address-size code `adsize` selects the offset: 0 uses `index_in[15:0]`, 1 uses `index_in[31:0]` and 2 uses all 64 bits, each zero-extended.
- R4: `mem_addr` is `es_base` plus the offset when `long_mode` is 0. When `long_mode` is 1 the base counts as zero and `mem_addr` equals the offset.
- R5: `mem_req` rises only in the cycle after the port acknowledge. `mem_wdata` carries the port data with the bytes above the element size forced to zero, and `mem_size` uses the same code as `io_size`.
- R6: The new index is the old one plus the element size (1, 2 or 4) when `dir_down` is 0, and minus that size when `dir_down` is 1.
- R7: The step wraps modulo the selected width. For code 0, bits 63:16 are kept. For code 1, bits 63:32 are cleared when `long_mode` is 1 and kept when it is 0. For code 2 the full 64 bits wrap.
- R8: With `long_mode` 1 only codes 1 and 2 are legal. With `long_mode` 0 only codes 0 and 1 are legal, and code 3 is never legal. An illegal start gives a one-cycle `fault` pulse in the next cycle, raises neither request, and leaves `index_out` unchanged.
- R9: A request stays high, with its address, size and data stable, until its acknowledge is sampled.
- R10: `index_out` changes only in the update step. `done` is high for exactly one cycle, which is the second cycle after the memory acknowledge is sampled, and by then `index_out` already holds the new value.
- R11: After reset, `io_req`, `mem_req`, `done`, `fault` and `busy` are low and `index_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| opcode | input | 8 | Decoded opcode byte |
| opsize32 | input | 1 | Operand-size attribute, 1 = 32-bit |
| adsize | input | 2 | Address-size code, 0/1/2 = 16/32/64-bit |
| long_mode | input | 1 | 64-bit mode flag |
| dir_down | input | 1 | Direction flag, 1 = decrement |
| port_reg | input | 16 | Port register value |
| index_in | input | 64 | Destination index register value |
| es_base | input | 64 | Extra-segment base |
| io_req | output | 1 | Port read request |
| io_addr | output | 16 | Port address |
| io_size | output | 2 | Port element size code |
| io_ack | input | 1 | Port read acknowledge |
| io_rdata | input | 32 | Port read data |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_size | output | 2 | Memory element size code |
| mem_ack | input | 1 | Memory write acknowledge |
| index_out | output | 64 | Updated index register value |
| done | output | 1 | Operation completed |
| fault | output | 1 | Illegal combination, nothing done |
| busy | output | 1 | Operation in progress |

## Verification
The bench steps through every combination of opcode (byte, wide and an illegal code), operand size, address-size code, mode and direction flag. Each combination runs against index values that sit right at the 16-, 32- and 64-bit wrap points, with upper bits that are either set or clear. These index patterns separate a wrap at the wrong width, dropped or kept upper bits, and a wrong step direction or size. Flipping the mode with the same base shows whether the segment base is added or left out. Port and memory acknowledges arrive after varying delays, which checks that both requests hold their values while they wait. The illegal address-size and opcode cases check that nothing reaches either bus and that the index result stays as it was.

// File: rtl/strio_pkg.sv
package strio_pkg;
  localparam logic [7:0] OPC_BYTE = 8'h6C;
  localparam logic [7:0] OPC_WIDE = 8'h6D;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } xfer_sz_e;

  localparam logic [1:0] AW_16 = 2'd0;
  localparam logic [1:0] AW_32 = 2'd1;
  localparam logic [1:0] AW_64 = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PORT = 3'd1,
    ST_MEM  = 3'd2,
    ST_UPD  = 3'd3,
    ST_DONE = 3'd4,
    ST_FLT  = 3'd5
  } st_e;
endpackage

// File: rtl/strio_decode.sv
module strio_decode
  import strio_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       opsize32,
  input  logic [1:0] adsize,
  input  logic       long_mode,
  output logic       legal,
  output xfer_sz_e   xsz
);
  logic opc_ok;
  logic aw_ok;

  always_comb begin
    opc_ok = (opcode == OPC_BYTE) || (opcode == OPC_WIDE);
    if (long_mode) aw_ok = (adsize == AW_32) || (adsize == AW_64);
    else           aw_ok = (adsize == AW_16) || (adsize == AW_32);
    legal = opc_ok && aw_ok;
    if (opcode == OPC_BYTE) xsz = SZ_BYTE;
    else if (opsize32)      xsz = SZ_DWORD;
    else                    xsz = SZ_WORD;
  end
endmodule

// File: rtl/strio_addr.sv
module strio_addr
  import strio_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base,
  input  logic [1:0]    adsize,
  input  logic          long_mode,
  input  logic          dir_down,
  input  xfer_sz_e      xsz,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] idx_next,
  output logic [DW-1:0] wdata
);
  localparam int LANES = DW / 8;

  logic [2:0]    nbytes;
  logic [AW-1:0] step_ext;
  logic [AW-1:0] delta;
  logic [AW-1:0] offset;
  logic [AW-1:0] base_eff;
  logic [15:0]   lo16;
  logic [31:0]   lo32;

  always_comb begin
    case (xsz)
      SZ_BYTE:  nbytes = 3'd1;
      SZ_WORD:  nbytes = 3'd2;
      default:  nbytes = 3'd4;
    endcase
    step_ext = AW'(nbytes);
    delta    = dir_down ? (~step_ext + AW'(1)) : step_ext;
    lo16     = idx[15:0] + delta[15:0];
    lo32     = idx[31:0] + delta[31:0];

    case (adsize)
      AW_16:   offset = {{(AW-16){1'b0}}, idx[15:0]};
      AW_32:   offset = {{(AW-32){1'b0}}, idx[31:0]};
      default: offset = idx;
    endcase
    base_eff = long_mode ? '0 : base;
    mem_addr = base_eff + offset;

    case (adsize)
      AW_16:   idx_next = {idx[AW-1:16], lo16};
      AW_32:   idx_next = long_mode ? {{(AW-32){1'b0}}, lo32}
                                    : {idx[AW-1:32], lo32};
      default: idx_next = idx + delta;
    endcase
  end

  // byte lanes above the element size are forced to zero
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata[g*8 +: 8] = (3'(g) < nbytes) ? rdata[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/strio_unit.sv
module strio_unit
  import strio_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic          opsize32,
  input  logic [1:0]    adsize,
  input  logic          long_mode,
  input  logic          dir_down,
  input  logic [PW-1:0] port_reg,
  input  logic [AW-1:0] index_in,
  input  logic [AW-1:0] es_base,
  output logic          io_req,
  output logic [PW-1:0] io_addr,
  output logic [1:0]    io_size,
  input  logic          io_ack,
  input  logic [DW-1:0] io_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    mem_size,
  input  logic          mem_ack,
  output logic [AW-1:0] index_out,
  output logic          done,
  output logic          fault,
  output logic          busy
);
  st_e           state_q;
  logic          legal_q;
  xfer_sz_e      xsz_q;
  logic [1:0]    adsz_q;
  logic          lm_q;
  logic          dn_q;
  logic [PW-1:0] port_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] data_q;

  logic          dec_legal;
  xfer_sz_e      dec_sz;
  logic [AW-1:0] idx_next;

  strio_decode u_dec (
    .opcode   (opcode),
    .opsize32 (opsize32),
    .adsize   (adsize),
    .long_mode(long_mode),
    .legal    (dec_legal),
    .xsz      (dec_sz)
  );

  strio_addr #(.AW(AW), .DW(DW)) u_addr (
    .idx      (idx_q),
    .base     (base_q),
    .adsize   (adsz_q),
    .long_mode(lm_q),
    .dir_down (dn_q),
    .xsz      (xsz_q),
    .rdata    (data_q),
    .mem_addr (mem_addr),
    .idx_next (idx_next),
    .wdata    (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      legal_q   <= 1'b0;
      xsz_q     <= SZ_BYTE;
      adsz_q    <= '0;
      lm_q      <= 1'b0;
      dn_q      <= 1'b0;
      port_q    <= '0;
      idx_q     <= '0;
      base_q    <= '0;
      data_q    <= '0;
      index_out <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          legal_q <= dec_legal;
          xsz_q   <= dec_sz;
          adsz_q  <= adsize;
          lm_q    <= long_mode;
          dn_q    <= dir_down;
          port_q  <= port_reg;
          idx_q   <= index_in;
          base_q  <= es_base;
          state_q <= dec_legal ? ST_PORT : ST_FLT;
        end
        ST_PORT: if (io_ack) begin
          data_q  <= io_rdata;
          state_q <= ST_MEM;
        end
        ST_MEM: if (mem_ack) state_q <= ST_UPD;
        ST_UPD: begin
          index_out <= idx_next;
          state_q   <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign io_req   = (state_q == ST_PORT);
  assign mem_req  = (state_q == ST_MEM);
  assign done     = (state_q == ST_DONE);
  assign fault    = (state_q == ST_FLT);
  assign busy     = (state_q != ST_IDLE);
  assign io_addr  = port_q;
  assign io_size  = xsz_q;
  assign mem_size = xsz_q;

  AST_NO_IO_WHEN_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    io_req |-> legal_q); // R8
  AST_FAULT_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(start)); // R8
  AST_MEM_AFTER_PORT_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(io_ack)); // R5
  AST_IO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_ack) |=> (io_req && $stable(io_addr) && $stable(io_size))); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R9
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_UPD) |=> $stable(index_out)); // R10
  AST_ONE_BUS: assert property (@(posedge clk) disable iff (rst)
    !(io_req && mem_req)); // R5
endmodule

// File: tb/strio_unit_tb.sv
module strio_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        opsize32 = 1'b0;
  logic [1:0]  adsize = 2'd0;
  logic        long_mode = 1'b0;
  logic        dir_down = 1'b0;
  logic [15:0] port_reg = '0;
  logic [63:0] index_in = '0;
  logic [63:0] es_base = '0;
  logic        io_req;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic        io_ack = 1'b0;
  logic [31:0] io_rdata = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0;
  logic [63:0] index_out;
  logic        done;
  logic        fault;
  logic        busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [63:0] prev_idx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strio_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .opsize32(opsize32),
    .adsize(adsize), .long_mode(long_mode), .dir_down(dir_down),
    .port_reg(port_reg), .index_in(index_in), .es_base(es_base),
    .io_req(io_req), .io_addr(io_addr), .io_size(io_size), .io_ack(io_ack),
    .io_rdata(io_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_ack(mem_ack),
    .index_out(index_out), .done(done), .fault(fault), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pattern(input int k);
    case (k)
      0: pattern = 64'h0000_0000_0000_0000;
      1: pattern = 64'hABCD_0000_0000_FFFF;
      2: pattern = 64'h1234_5678_FFFF_FFFE;
      3: pattern = 64'hFFFF_FFFF_FFFF_FFFF;
      default: pattern = 64'h8000_0001_0001_0002;
    endcase
  endfunction

  task automatic run_op(input logic [7:0] opc, input bit wide, input logic [1:0] ad,
                        input bit lm, input bit dn, input logic [63:0] idx,
                        input logic [63:0] base, input logic [15:0] prt,
                        input logic [31:0] rd, input int io_wait, input int mem_wait);
    bit legal;
    int nb;
    logic [1:0] szc;
    logic [63:0] off, eaddr, nidx, d;
    logic [31:0] ewd;
    // expected values from the requirements
    legal = ((opc == 8'h6C) || (opc == 8'h6D)) &&
            (lm ? (ad == 2'd1 || ad == 2'd2) : (ad == 2'd0 || ad == 2'd1)); // R2 R8
    nb  = (opc == 8'h6C) ? 1 : (wide ? 4 : 2);
    szc = (nb == 1) ? 2'd0 : (nb == 2) ? 2'd1 : 2'd2;
    off = (ad == 2'd0) ? {48'h0, idx[15:0]} : (ad == 2'd1) ? {32'h0, idx[31:0]} : idx; // R3
    eaddr = (lm ? 64'h0 : base) + off; // R4
    d = dn ? (64'h0 - 64'(nb)) : 64'(nb); // R6
    if (ad == 2'd0)      nidx = {idx[63:16], 16'(idx[15:0] + d[15:0])}; // R7
    else if (ad == 2'd1) nidx = lm ? {32'h0, 32'(idx[31:0] + d[31:0])}
                                   : {idx[63:32], 32'(idx[31:0] + d[31:0])};
    else                 nidx = idx + d;
    ewd = (nb == 1) ? {24'h0, rd[7:0]} : (nb == 2) ? {16'h0, rd[15:0]} : rd;

    @(negedge clk);
    opcode = opc; opsize32 = wide; adsize = ad; long_mode = lm; dir_down = dn;
    index_in = idx; es_base = base; port_reg = prt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!legal) begin
      chk(fault === 1'b1, "R8 fault pulse", 64'(fault), 64'd1);
      chk(io_req === 1'b0 && mem_req === 1'b0, "R8 no access", {62'h0, io_req, mem_req}, 64'h0);
      chk(index_out === prev_idx, "R8 index unchanged", index_out, prev_idx);
      @(negedge clk);
      chk(fault === 1'b0 && busy === 1'b0, "R8 fault one cycle", {62'h0, fault, busy}, 64'h0);
      chk(index_out === prev_idx, "R8 index unchanged later", index_out, prev_idx);
      return;
    end
    chk(io_req === 1'b1 && io_addr === prt, "R1 port request", {47'h0, io_req, io_addr}, {47'h0, 1'b1, prt});
    chk(io_size === szc, "R2 port size", 64'(io_size), 64'(szc));
    for (int w = 0; w < io_wait; w++) begin
      @(negedge clk);
      chk(io_req === 1'b1 && mem_req === 1'b0 && io_addr === prt, "R9 port hold",
          {46'h0, io_req, mem_req, io_addr}, {46'h0, 2'b10, prt});
    end
    io_ack = 1'b1; io_rdata = rd;
    @(negedge clk);
    io_ack = 1'b0; io_rdata = ~rd;
    chk(mem_req === 1'b1 && io_req === 1'b0, "R5 memory request", {62'h0, mem_req, io_req}, 64'h2);
    chk(mem_addr === eaddr, (ad == 2'd2) ? "R3 R4 address 64" : "R3 R4 address", mem_addr, eaddr);
    chk(mem_wdata === ewd && mem_size === szc, "R5 write data",
        {30'h0, mem_size, mem_wdata}, {30'h0, szc, ewd});
    chk(index_out === prev_idx, "R10 index held during write", index_out, prev_idx);
    for (int w = 0; w < mem_wait; w++) begin
      @(negedge clk);
      chk(mem_req === 1'b1 && mem_addr === eaddr && mem_wdata === ewd, "R9 memory hold",
          mem_addr, eaddr);
    end
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(done === 1'b0 && index_out === prev_idx, "R10 no early done", index_out, prev_idx);
    @(negedge clk);
    chk(done === 1'b1, "R10 done pulse", 64'(done), 64'd1);
    chk(index_out === nidx, dn ? "R6 R7 index down" : "R6 R7 index up", index_out, nidx);
    prev_idx = nidx;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10 done one cycle", {62'h0, done, busy}, 64'h0);
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(io_req === 1'b0 && mem_req === 1'b0 && done === 1'b0 && fault === 1'b0 && busy === 1'b0,
        "R11 reset outputs", {59'h0, io_req, mem_req, done, fault, busy}, 64'h0);
    chk(index_out === 64'h0, "R11 reset index", index_out, 64'h0);
    for (int o = 0; o < 3; o++)
      for (int wd = 0; wd < 2; wd++)
        for (int a = 0; a < 4; a++)
          for (int m = 0; m < 2; m++)
            for (int dn = 0; dn < 2; dn++)
              for (int k = 0; k < 5; k++) begin
                logic [7:0] opc;
                opc = (o == 0) ? 8'h6C : (o == 1) ? 8'h6D : 8'h6E;
                run_op(opc, wd[0], a[1:0], m[0], dn[0], pattern(k),
                       64'h0000_0000_0010_0000 + 64'(n * 64'h1_0010),
                       16'hFFFF ^ 16'(n * 37), 32'hA1B2_C3D4 ^ 32'(n * 32'h0101_0101),
                       n % 3, n % 2);
                n++;
              end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule